// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Interrupt Controller

This block is shared by all the pins of a GPIO controller. Each pin's own logic reports one pending-and-unmasked flag. The block folds those flags into a compact summary, in which one bit stands for a group of four neighbouring pins, and exposes that summary as two 32-bit status words. It drives a single interrupt line to the host. Software acknowledges an interrupt with an end-of-interrupt pulse, and the line then re-arms from whatever is still pending.

The block also provides a settling guard. When the status-masking enable is on, any write to a pin's debounce settings opens a window that suppresses status generation for every pin. A 12-bit length sets how many RTC ticks the window lasts. While the window is open, the block raises a global block flag. The per-pin logic uses that flag to make its interrupt-enable readback show 0, and software polls that readback to learn when settling is over.

Top module: `gpio_irq_summary`

## Requirements
- R1: One clock edge after the pending flags change, summary bit n equals the OR of the flags of pins 4n, 4n+1, 4n+2 and 4n+3.
- R2: Summary bits 0 to 31 appear on `sum_lo[31:0]`. Bits 32 to 45 appear on `sum_hi[13:0]`. `sum_hi[31:14]` is always 0.
- R3: `host_irq` is high one edge after any summary bit is set, and low one edge after all summary bits are clear.
- R4: The cycle after an `eoi_wr` pulse, `host_irq` is low. On the following cycle it is high again if a summary bit is still set.
- R5: A debounce write (`dbnc_wr` bit high) while `mask_sts_en` is 1 and `mask_sts_len` is nonzero raises `status_block` after the next edge. `status_block` stays high until exactly `mask_sts_len` `rtc_tick` pulses have been counted.
- R6: While `status_block` is high, the summary registers load zero, so both status words and `host_irq` fall to 0.
- R7: A debounce write during an open window reloads the full length, so the count restarts.
- R8: A debounce write while `mask_sts_en` is 0, or while `mask_sts_len` is 0, has no effect on `status_block`.
- R9: After reset, both status words, `host_irq` and `status_block` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle pulse per RTC period |
| pin_pend | input | 184 | Per-pin pending-and-unmasked flags |
| dbnc_wr | input | 184 | Per-pin debounce-configuration write pulses |
| mask_sts_en | input | 1 | Enables the status-blocking window |
| mask_sts_len | input | 12 | Window length in RTC ticks |
| eoi_wr | input | 1 | End-of-interrupt pulse; the bit self-clears |
| sum_lo | output | 32 | Summary status bits 0 to 31 |
| sum_hi | output | 32 | Summary status bits 32 to 45 in [13:0] |
| host_irq | output | 1 | Interrupt line to the host |
| status_block | output | 1 | Global blocking-window flag |

## Verification
The hardest situation to reach is a window restart. A second debounce write has to arrive after some ticks of the window have already been counted. Only then does the difference between reloading the full length and continuing the old count become visible. The bench holds a pin pending, opens a three-tick window, and spends two ticks. It then writes a different pin's debounce settings and counts three further ticks before expecting the block flag and the interrupt to return. It also places pending pins at the group edges, including the last pin and the pins on either side of the word split, to confirm the summary mapping.

// File: rtl/gpio_sum_pkg.sv
package gpio_sum_pkg;
  localparam int STAT_W = 32;

  // summary bit that covers a given pin
  function automatic int grp_of_pin(input int pin, input int grp);
    return pin / grp;
  endfunction

  // number of summary bits for a pin count
  function automatic int grp_count(input int pins, input int grp);
    return (pins + grp - 1) / grp;
  endfunction
endpackage

// File: rtl/gpio_sum_reduce.sv
module gpio_sum_reduce #(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4,
  parameter int NB       = 46
) (
  input  logic [NUM_PINS-1:0] pend,
  input  logic                block,
  output logic [NB-1:0]       grp_any
);
  localparam int PAD = NB * GRP;
  logic [PAD-1:0] padded;
  assign padded = PAD'(pend);

  for (genvar g = 0; g < NB; g++) begin : g_grp
    assign grp_any[g] = (|padded[g*GRP +: GRP]) & ~block;
  end
endmodule

// File: rtl/gpio_blk_timer.sv
module gpio_blk_timer #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= len;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic any_sum,
  input  logic eoi,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_sum & ~eoi;
  end
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS = 184,
  parameter int GRP      = 4,
  parameter int LEN_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rtc_tick,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [NUM_PINS-1:0] dbnc_wr,
  input  logic                mask_sts_en,
  input  logic [LEN_W-1:0]    mask_sts_len,
  input  logic                eoi_wr,
  output logic [31:0]         sum_lo,
  output logic [31:0]         sum_hi,
  output logic                host_irq,
  output logic                status_block
);
  import gpio_sum_pkg::*;
  localparam int NB  = grp_count(NUM_PINS, GRP);
  localparam int TOT = 2 * STAT_W;

  logic          dbnc_any;
  logic          blk_load;
  logic [NB-1:0] grp_any;
  logic [NB-1:0] sum_q;
  logic          sum_nonzero;
  logic [TOT-1:0] sum_wide;

  assign dbnc_any = |dbnc_wr;
  assign blk_load = dbnc_any & mask_sts_en & (mask_sts_len != '0);

  gpio_blk_timer #(.LEN_W(LEN_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .tick(rtc_tick),
    .len(mask_sts_len), .active(status_block)
  );

  gpio_sum_reduce #(.NUM_PINS(NUM_PINS), .GRP(GRP), .NB(NB)) reduce_i (
    .pend(pin_pend), .block(status_block), .grp_any(grp_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= grp_any;
  end

  assign sum_nonzero = |sum_q;
  assign sum_wide    = TOT'(sum_q);
  assign sum_lo      = sum_wide[STAT_W-1:0];
  assign sum_hi      = sum_wide[TOT-1:STAT_W];

  gpio_irq_line line_i (
    .clk(clk), .rst_n(rst_n), .any_sum(sum_nonzero), .eoi(eoi_wr), .irq(host_irq)
  );
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
  parameter int NUM_PINS = 184,
  parameter int LEN_W    = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rtc_tick,
  input logic [NUM_PINS-1:0] dbnc_wr,
  input logic                mask_sts_en,
  input logic [LEN_W-1:0]    mask_sts_len,
  input logic                eoi_wr,
  input logic [31:0]         sum_lo,
  input logic [31:0]         sum_hi,
  input logic                host_irq,
  input logic                status_block
);
  a_r4_eoi_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr |=> !host_irq);

  a_r3_irq_needs_summary: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(sum_lo != 32'd0 || sum_hi != 32'd0));

  a_r5_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_sts_en && (|dbnc_wr) && mask_sts_len != '0) |=> status_block);

  a_r5_window_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_block && !rtc_tick) |=> status_block);

  a_r6_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    status_block |=> (sum_lo == 32'd0 && sum_hi == 32'd0));

  a_r8_off_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_sts_en && !status_block) |=> !status_block);
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(.NUM_PINS(NUM_PINS), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .dbnc_wr(dbnc_wr),
  .mask_sts_en(mask_sts_en), .mask_sts_len(mask_sts_len), .eoi_wr(eoi_wr),
  .sum_lo(sum_lo), .sum_hi(sum_hi), .host_irq(host_irq), .status_block(status_block)
);

// File: tb/gpio_irq_summary_tb_top.sv
module gpio_irq_summary_tb_top;
  localparam int NP = 184;
  localparam int NV = 8;
  // pin index, expected summary bit (pin divided by four)
  localparam int VEC [NV][2] = '{
    '{0, 0}, '{3, 0}, '{4, 1}, '{61, 15},
    '{90, 22}, '{127, 31}, '{128, 32}, '{183, 45}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rtc_tick = 1'b0;
  logic [NP-1:0] pin_pend = '0;
  logic [NP-1:0] dbnc_wr = '0;
  logic mask_sts_en = 1'b0;
  logic [11:0] mask_sts_len = '0;
  logic eoi_wr = 1'b0;
  logic [31:0] sum_lo, sum_hi;
  logic host_irq, status_block;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gpio_irq_summary dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pin_pend(pin_pend),
    .dbnc_wr(dbnc_wr), .mask_sts_en(mask_sts_en), .mask_sts_len(mask_sts_len),
    .eoi_wr(eoi_wr), .sum_lo(sum_lo), .sum_hi(sum_hi),
    .host_irq(host_irq), .status_block(status_block)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    rtc_tick = 1'b1; step(1); rtc_tick = 1'b0;
  endtask

  task automatic dbnc_pulse(input int pin);
    dbnc_wr[pin] = 1'b1; step(1); dbnc_wr = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] exp_sum;
    step(3);
    // R9 reset state
    chk({sum_hi, sum_lo} == 64'd0 && !host_irq && !status_block, "R9",
        {sum_hi, sum_lo}, 64'd0);
    rst_n = 1'b1;
    step(2);

    // R1 R2 R3 table walk: single pending pin
    for (int v = 0; v < NV; v++) begin
      pin_pend = '0;
      pin_pend[VEC[v][0]] = 1'b1;
      step(2);
      exp_sum = 64'd1 << VEC[v][1];
      chk({sum_hi, sum_lo} == exp_sum, "R1 R2", {sum_hi, sum_lo}, exp_sum);
      chk(host_irq == 1'b1, "R3", 64'(host_irq), 64'd1);
    end

    // R1 two pins in one group plus one elsewhere
    pin_pend = '0;
    pin_pend[9] = 1'b1; pin_pend[10] = 1'b1; pin_pend[140] = 1'b1;
    step(2);
    exp_sum = (64'd1 << 2) | (64'd1 << 35);
    chk({sum_hi, sum_lo} == exp_sum, "R1", {sum_hi, sum_lo}, exp_sum);
    // R2 upper bits of high word unused even with all pins pending
    pin_pend = '1;
    step(2);
    chk(sum_hi == 32'h0000_3FFF && sum_lo == 32'hFFFF_FFFF, "R2",
        {sum_hi, sum_lo}, {32'h0000_3FFF, 32'hFFFF_FFFF});

    // R3 line falls when nothing pending
    pin_pend = '0;
    step(2);
    chk(!host_irq && {sum_hi, sum_lo} == 64'd0, "R3", 64'(host_irq), 64'd0);

    // R4 EOI drops the line one cycle then it re-arms
    pin_pend[20] = 1'b1;
    step(2);
    eoi_wr = 1'b1; step(1); eoi_wr = 1'b0;
    chk(host_irq == 1'b0, "R4 drop", 64'(host_irq), 64'd0);
    step(1);
    chk(host_irq == 1'b1, "R4 rearm", 64'(host_irq), 64'd1);

    // R5 R6 window of three ticks with pin 20 pending
    mask_sts_en = 1'b1; mask_sts_len = 12'd3;
    dbnc_pulse(7);
    chk(status_block == 1'b1, "R5 open", 64'(status_block), 64'd1);
    step(1);
    chk({sum_hi, sum_lo} == 64'd0, "R6 summary", {sum_hi, sum_lo}, 64'd0);
    step(1);
    chk(host_irq == 1'b0, "R6 line", 64'(host_irq), 64'd0);
    pulse_tick(); pulse_tick();
    chk(status_block == 1'b1, "R5 hold", 64'(status_block), 64'd1);
    // R7 reload mid-window
    dbnc_pulse(100);
    pulse_tick(); pulse_tick();
    chk(status_block == 1'b1, "R7 restart", 64'(status_block), 64'd1);
    pulse_tick();
    chk(status_block == 1'b0, "R7 close", 64'(status_block), 64'd0);
    step(2);
    chk(host_irq == 1'b1 && sum_lo == 32'd1 << 5, "R5 resume",
        {sum_hi, sum_lo}, 64'd1 << 5);

    // R5 exact length: window closes on the third tick
    dbnc_pulse(1);
    pulse_tick(); pulse_tick(); pulse_tick();
    chk(status_block == 1'b0, "R5 close", 64'(status_block), 64'd0);

    // R8 disabled enable and zero length
    mask_sts_en = 1'b0;
    dbnc_pulse(50);
    chk(status_block == 1'b0, "R8 en off", 64'(status_block), 64'd0);
    step(1);
    chk(host_irq == 1'b1, "R8 line kept", 64'(host_irq), 64'd1);
    mask_sts_en = 1'b1; mask_sts_len = 12'd0;
    dbnc_pulse(50);
    chk(status_block == 1'b0, "R8 len zero", 64'(status_block), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule